// File: doc/BRIEF.md
# Multi-dimensional vector index remapper

This block produces the element indices for a hardware vector loop. A linear step counter runs from 0 up to the loop length minus one, and the block turns each step into one index for each of four operand slots. Three of the slots are sources and one is the destination. A slot can take the linear step unchanged. It can also take its index from one of four shape registers, and each shape describes a walk over a box of up to three dimensions.

A shape stores three dimension sizes, a walk order and a base offset. The walk order decides which coordinate counts fastest, so one slot can step across a matrix by columns while another steps by rows. One multiply-accumulate repeated once per step can then cover a full matrix product. When the outermost coordinate passes its last value, the walk starts again from the origin. A short shape therefore repeats over a long loop. Sub-vector elements are treated as extra steps of the same loop.

Software writes the shape registers through a simple write port. The issue logic chooses the shape for each slot, sets the loop length and sub-vector length, pulses `start`, and then raises `step` once for each consumed index. It stops when it sees `done`.

Top module: `vidx_remap`

## Requirements
- R1: After a synchronous active-low reset, `idx_valid` and `done` are low, and all four shape registers read as dimensions 1x1x1 with offset 0.
- R2: When `start` is high while `idx_valid` is low, the block captures the loop length, the sub-vector length, the slot selects and the selected shapes. `idx_valid` rises on the next cycle and carries the indices for step 0. If `start` is high while `idx_valid` is high, it is ignored.
- R3: Each cycle in which `idx_valid` and `step` are both high moves the loop forward by one step. While `step` is low, the indices and `idx_valid` hold.
- R4: A loop has `(vl_m1+1)*(subvl_m1+1)` steps. `done` is high exactly while the last step's indices are valid. A `step` taken in that cycle drops `idx_valid` on the next cycle.
- R5: `slot_sel` holds 3 bits per slot, with slot k at bits [3k+2:3k]. Bit 2 enables remapping and bits 1:0 pick the shape. A slot with bit 2 clear outputs the linear step number.
- R6: A shape word has these fields: [7:0] base offset, [13:8] xdim-1, [19:14] ydim-1, [25:20] zdim-1, [28:26] walk order. `cfg_we` writes `cfg_wdata` into the shape that `cfg_addr` names.
- R7: The walk-order codes are 0=xyz, 1=xzy, 2=yxz, 3=yzx, 4=zxy and 5=zyx. The first letter is the coordinate that wraps first. Codes 6 and 7 behave as xyz. A remapped index equals x + xdim*y + xdim*ydim*z + offset.
- R8: After the outermost coordinate wraps, the walk starts again from the origin. A 1D shape with xdim=16 over 64 steps gives 0..15 four times.
- R9: A shape with xdim=4, ydim=1 and order xyz gives step mod 4.
- R10: A shape with xdim=4, ydim=4 and order yxz gives the transposed walk 0,4,8,12,1,5,9,13,...
- R11: Writing a shape register while a loop is active does not affect that loop. The new value is used from the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Shape register write enable |
| cfg_addr | input | 2 | Shape register number |
| cfg_wdata | input | 29 | Shape word (fields as in R6) |
| slot_sel | input | 12 | Per-slot enable and shape select (R5) |
| vl_m1 | input | 7 | Loop length minus one |
| subvl_m1 | input | 2 | Sub-vector length minus one |
| start | input | 1 | Begin a loop |
| step | input | 1 | Consume the current indices |
| idx_valid | output | 1 | Indices are valid |
| done | output | 1 | Current indices belong to the last step |
| idx | output | 76 | Four 19-bit indices, slot k at bits [19k+18:19k] |

## Verification
The step-0 indices are due one clock after the edge that accepts `start`. Each later index set is due one clock after an edge where `step` was high. `done` arrives with the last index set, and `idx_valid` falls one clock after the final step. The bench drives and samples 1 ns after each rising edge, so every value it reads is the one registered by the edge just passed. It compares the values against indices computed by division and modulo from the captured configuration. Random gaps in `step` show that outputs hold between steps. A shape write and a repeated `start` issued in the middle of a loop are checked over the remaining steps of that loop.

// File: rtl/vidx_pkg.sv
// Shared field widths, shape word layout and walk-order decode for the index remapper.
// Assumes at most three dimensions and a 3-bit order code.
package vidx_pkg;

    localparam int DIM_W   = 6;
    localparam int OFF_W   = 8;
    localparam int ORD_W   = 3;
    localparam int AXIS_W  = 2;

    // Shape word; a packed struct puts its first member at the MSB
    typedef struct packed {
        logic [ORD_W-1:0] order;
        logic [DIM_W-1:0] zm1;
        logic [DIM_W-1:0] ym1;
        logic [DIM_W-1:0] xm1;
        logic [OFF_W-1:0] off;
    } shape_t;

    localparam int SHAPE_W = $bits(shape_t);

    // Axis numbers used by the walk: 0=x, 1=y, 2=z
    typedef struct packed {
        logic [AXIS_W-1:0] outer;
        logic [AXIS_W-1:0] mid;
        logic [AXIS_W-1:0] inner;
    } walk_t;

    // Turns an order code into inner/mid/outer axes; unused codes fall back to xyz
    function automatic walk_t order_decode(input logic [ORD_W-1:0] code);
        walk_t w;
        case (code)
            3'd1:    w = '{outer: 2'd1, mid: 2'd2, inner: 2'd0};
            3'd2:    w = '{outer: 2'd2, mid: 2'd0, inner: 2'd1};
            3'd3:    w = '{outer: 2'd0, mid: 2'd2, inner: 2'd1};
            3'd4:    w = '{outer: 2'd1, mid: 2'd0, inner: 2'd2};
            3'd5:    w = '{outer: 2'd0, mid: 2'd1, inner: 2'd2};
            default: w = '{outer: 2'd2, mid: 2'd1, inner: 2'd0};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/vidx_shape_bank.sv
// Bank of shape configuration registers with one write port.
// All registers are read in parallel; each slot takes its own copy when a loop starts.
module vidx_shape_bank
    import vidx_pkg::*;
#(
    parameter int NSHAPE = 4,
    localparam int ADDR_W = (NSHAPE > 1) ? $clog2(NSHAPE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  shape_t            wdata,
    output shape_t            shapes [NSHAPE]
);

    // Holds each shape register; a reset gives 1x1x1 dimensions with zero offset
    always_ff @(posedge clk) begin
        for (int i = 0; i < NSHAPE; i++) begin
            if (!rst_n)
                shapes[i] <= '0;
            else if (we && (addr == ADDR_W'(i)))
                shapes[i] <= wdata;
        end
    end

endmodule

// File: rtl/vidx_step_ctrl.sv
// Loop sequencer: accepts start, counts linear steps and flags the last one.
// Assumes the loop length and sub-vector length are steady in the start cycle.
module vidx_step_ctrl #(
    parameter int VL_W  = 7,
    parameter int SUB_W = 2,
    localparam int CNT_W = VL_W + SUB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic [VL_W-1:0]  vl_m1,
    input  logic [SUB_W-1:0] subvl_m1,
    output logic             load,
    output logic             adv,
    output logic             valid,
    output logic             last,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] total_m1;
    logic [CNT_W:0]   total_c;

    // Step count of the loop being started: (vl) * (subvl) - 1
    always_comb begin
        total_c = (CNT_W+1)'((VL_W+1)'(vl_m1) + 1'b1) * (CNT_W+1)'((SUB_W+1)'(subvl_m1) + 1'b1) - 1'b1;
        load    = start && !valid;
        last    = valid && (cnt == total_m1);
        adv     = valid && step && !last;
    end

    // Tracks the loop state: valid flag, linear step counter and captured length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            cnt      <= '0;
            total_m1 <= '0;
        end else if (load) begin
            valid    <= 1'b1;
            cnt      <= '0;
            total_m1 <= total_c[CNT_W-1:0];
        end else if (valid && step) begin
            if (last)
                valid <= 1'b0;
            else
                cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/vidx_slot_walk.sv
// One operand slot: takes its own copy of the selected shape at start and keeps wrapping
// coordinate counters that advance in the captured walk order.
// Assumes load and adv are never high together.
module vidx_slot_walk
    import vidx_pkg::*;
#(
    parameter int NSHAPE = 4,
    parameter int CNT_W  = 9,
    parameter int IDX_W  = 3*DIM_W + 1,
    localparam int SEL_ID_W = (NSHAPE > 1) ? $clog2(NSHAPE) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                adv,
    input  logic                sel_en,
    input  logic [SEL_ID_W-1:0] sel_id,
    input  shape_t              shapes [NSHAPE],
    input  logic [CNT_W-1:0]    lin_cnt,
    output logic [IDX_W-1:0]    idx
);

    localparam int NAXIS = 3;

    logic             en_q;
    shape_t           shp_q;
    logic [DIM_W-1:0] coord  [NAXIS];
    logic [DIM_W-1:0] nxt    [NAXIS];
    logic [DIM_W-1:0] dm1    [NAXIS];
    walk_t            walk;

    // Dimension limits and walk order of the captured shape
    always_comb begin
        dm1[0] = shp_q.xm1;
        dm1[1] = shp_q.ym1;
        dm1[2] = shp_q.zm1;
        walk   = order_decode(shp_q.order);
    end

    // Next coordinates: inner counts first, carries ripple outward, outer wraps to origin
    always_comb begin
        for (int a = 0; a < NAXIS; a++) nxt[a] = coord[a];
        if (coord[walk.inner] != dm1[walk.inner]) begin
            nxt[walk.inner] = coord[walk.inner] + 1'b1;
        end else begin
            nxt[walk.inner] = '0;
            if (coord[walk.mid] != dm1[walk.mid]) begin
                nxt[walk.mid] = coord[walk.mid] + 1'b1;
            end else begin
                nxt[walk.mid] = '0;
                if (coord[walk.outer] != dm1[walk.outer])
                    nxt[walk.outer] = coord[walk.outer] + 1'b1;
                else
                    nxt[walk.outer] = '0;
            end
        end
    end

    // Captures slot select and shape at start, then steps the coordinates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            shp_q <= '0;
            for (int a = 0; a < NAXIS; a++) coord[a] <= '0;
        end else if (load) begin
            en_q  <= sel_en;
            shp_q <= shapes[sel_id];
            for (int a = 0; a < NAXIS; a++) coord[a] <= '0;
        end else if (adv) begin
            for (int a = 0; a < NAXIS; a++) coord[a] <= nxt[a];
        end
    end

    logic [DIM_W:0]   xd, yd;
    logic [IDX_W-1:0] plane, remap;

    // Index = x + xdim*y + xdim*ydim*z + offset, or the linear step when disabled
    always_comb begin
        xd    = (DIM_W+1)'(shp_q.xm1) + 1'b1;
        yd    = (DIM_W+1)'(shp_q.ym1) + 1'b1;
        plane = IDX_W'(xd) * IDX_W'(yd);
        remap = IDX_W'(coord[0])
              + IDX_W'(xd) * IDX_W'(coord[1])
              + plane * IDX_W'(coord[2])
              + IDX_W'(shp_q.off);
        idx   = en_q ? remap : IDX_W'(lin_cnt);
    end

endmodule

// File: rtl/vidx_remap.sv
// Top of the vector index remapper: shape bank, loop sequencer and one walker per slot.
// Assumes slot_sel, vl_m1 and subvl_m1 are steady in the cycle where start is accepted.
module vidx_remap
    import vidx_pkg::*;
#(
    parameter int NSLOT  = 4,
    parameter int NSHAPE = 4,
    parameter int VL_W   = 7,
    parameter int SUB_W  = 2,
    localparam int ADDR_W = (NSHAPE > 1) ? $clog2(NSHAPE) : 1,
    localparam int SEL_W  = ADDR_W + 1,
    localparam int IDX_W  = 3*DIM_W + 1,
    localparam int CNT_W  = VL_W + SUB_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [SHAPE_W-1:0]     cfg_wdata,
    input  logic [NSLOT*SEL_W-1:0] slot_sel,
    input  logic [VL_W-1:0]        vl_m1,
    input  logic [SUB_W-1:0]       subvl_m1,
    input  logic                   start,
    input  logic                   step,
    output logic                   idx_valid,
    output logic                   done,
    output logic [NSLOT*IDX_W-1:0] idx
);

    shape_t           shapes [NSHAPE];
    logic             load, adv, last;
    logic [CNT_W-1:0] cnt;

    vidx_shape_bank #(.NSHAPE(NSHAPE)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (shape_t'(cfg_wdata)),
        .shapes (shapes)
    );

    vidx_step_ctrl #(.VL_W(VL_W), .SUB_W(SUB_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .step     (step),
        .vl_m1    (vl_m1),
        .subvl_m1 (subvl_m1),
        .load     (load),
        .adv      (adv),
        .valid    (idx_valid),
        .last     (last),
        .cnt      (cnt)
    );

    assign done = last;

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        vidx_slot_walk #(.NSHAPE(NSHAPE), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_walk (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .adv     (adv),
            .sel_en  (slot_sel[k*SEL_W + ADDR_W]),
            .sel_id  (slot_sel[k*SEL_W +: ADDR_W]),
            .shapes  (shapes),
            .lin_cnt (cnt),
            .idx     (idx[k*IDX_W +: IDX_W])
        );
    end

endmodule

// File: rtl/vidx_remap_chk.sv
// Protocol checks on the remapper's ports, bound into every instance of the top.
module vidx_remap_chk #(
    parameter int FLAT_W = 76
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              step,
    input logic              idx_valid,
    input logic              done,
    input logic [FLAT_W-1:0] idx
);

    // R4: done only appears together with valid indices
    a_r4_done_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> idx_valid);

    // R4: stepping past the last indices ends the loop
    a_r4_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (done && step) |=> !idx_valid);

    // R3: without a step the indices and valid hold
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && !step) |=> (idx_valid && $stable(idx)));

    // R3: a step before the last keeps the loop running
    a_r3_continue: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && step && !done) |=> idx_valid);

    // R2: an accepted start makes indices valid on the next cycle
    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !idx_valid) |=> idx_valid);

endmodule

bind vidx_remap vidx_remap_chk #(.FLAT_W(NSLOT*IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .step      (step),
    .idx_valid (idx_valid),
    .done      (done),
    .idx       (idx)
);

// File: tb/sim_vidx_remap.sv
// Bench for vidx_remap: directed shape cases followed by random loops, with expected values
// from division and modulo.
module sim_vidx_remap;

    localparam int IW = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [28:0] cfg_wdata = '0;
    logic [11:0] slot_sel = '0;
    logic [6:0]  vl_m1 = '0;
    logic [1:0]  subvl_m1 = '0;
    logic        start = 1'b0;
    logic        step = 1'b0;
    logic        idx_valid, done;
    logic [4*IW-1:0] idx;

    int tests = 0;
    int fails = 0;
    logic [28:0] shp_m [4];

    always #2.5 clk = ~clk;

    vidx_remap u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .slot_sel(slot_sel), .vl_m1(vl_m1),
        .subvl_m1(subvl_m1), .start(start), .step(step),
        .idx_valid(idx_valid), .done(done), .idx(idx)
    );

    // Builds a shape word (R6): order [28:26], zdim-1, ydim-1, xdim-1, offset [7:0]
    function automatic logic [28:0] mk(int ord, int xd, int yd, int zd, int off);
        return {3'(ord), 6'(zd-1), 6'(yd-1), 6'(xd-1), 8'(off)};
    endfunction

    // Expected index of one step (R7, R8): coordinates from division by the inner dimensions
    function automatic int exp_idx(logic [28:0] w, int s);
        int d[3], c[3], inn, mid, out;
        d[0] = int'(w[13:8]) + 1;
        d[1] = int'(w[19:14]) + 1;
        d[2] = int'(w[25:20]) + 1;
        case (w[28:26])
            3'd1: begin inn = 0; mid = 2; out = 1; end
            3'd2: begin inn = 1; mid = 0; out = 2; end
            3'd3: begin inn = 1; mid = 2; out = 0; end
            3'd4: begin inn = 2; mid = 0; out = 1; end
            3'd5: begin inn = 2; mid = 1; out = 0; end
            default: begin inn = 0; mid = 1; out = 2; end
        endcase
        c[inn] = s % d[inn];
        c[mid] = (s / d[inn]) % d[mid];
        c[out] = (s / (d[inn] * d[mid])) % d[out];
        return c[0] + d[0] * c[1] + d[0] * d[1] * c[2] + int'(w[7:0]);
    endfunction

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [28:0] d);
        cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        shp_m[a] = d;
    endtask

    // Runs one loop; gaps inserts idle cycles, midwr>=0 writes a shape and repeats start there
    task automatic run(string tag, int vm1, int sm1, bit gaps, int midwr);
        logic [28:0] snap [4];
        logic [11:0] sel;
        int total, s, e;
        vl_m1 = 7'(vm1); subvl_m1 = 2'(sm1);
        snap = shp_m; sel = slot_sel;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        total = (vm1 + 1) * (sm1 + 1);
        s = 0;
        while (s < total) begin
            chk({tag, " R2/R3 valid"}, int'(idx_valid), 1);
            for (int k = 0; k < 4; k++) begin
                // R5: bit 2 of each 3-bit select enables remapping, bits 1:0 pick the shape
                e = sel[3*k+2] ? exp_idx(snap[sel[3*k +: 2]], s) : s;
                chk({tag, $sformatf(" slot%0d step%0d", k, s)}, int'(idx[k*IW +: IW]), e);
            end
            chk({tag, " R4 done"}, int'(done), int'(s == total - 1));
            if (gaps && ($urandom % 4 == 0)) begin
                step = 1'b0;
                @(posedge clk); #1;
                continue;
            end
            if (s == midwr) begin
                // R11 write mid-loop; R2 repeated start ignored
                cfg_we = 1'b1; cfg_addr = 2'($urandom % 4); cfg_wdata = 29'($urandom);
                shp_m[cfg_addr] = cfg_wdata;
                start = 1'b1;
            end
            step = 1'b1;
            @(posedge clk); #1;
            step = 1'b0; cfg_we = 1'b0; start = 1'b0;
            s++;
        end
        chk({tag, " R4 valid drops"}, int'(idx_valid), 0);
        chk({tag, " R4 done low"}, int'(done), 0);
    endtask

    // Ends a hung run as a failure
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) shp_m[i] = '0;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        // R1: idle after reset
        chk("R1 valid", int'(idx_valid), 0);
        chk("R1 done", int'(done), 0);
        // R1: reset shapes are 1x1x1 offset 0, so every remapped index is 0
        slot_sel = {3'b111, 3'b110, 3'b101, 3'b100};
        run("R1 reset shapes", 3, 0, 1'b0, -1);

        // R9 mod-4 walk, R10 transpose, R8 rotation, R5 linear slot
        wr(0, mk(0, 4, 1, 1, 0));
        wr(1, mk(2, 4, 4, 1, 0));
        wr(2, mk(0, 16, 1, 1, 0));
        slot_sel = {3'b110, 3'b101, 3'b000, 3'b100};
        run("R8 R9 R10 R5", 63, 0, 1'b0, -1);

        // R7: 3D walks with offset, codes 7 fall back to xyz; R4 sub-vector count
        wr(0, mk(3, 3, 2, 4, 17));
        wr(3, mk(7, 2, 3, 2, 200));
        slot_sel = {3'b111, 3'b011, 3'b100, 3'b100};
        run("R7 R4 subvl", 4, 2, 1'b1, -1);

        // R11 and R2: write and repeated start in the middle of a loop
        slot_sel = {3'b100, 3'b101, 3'b110, 3'b111};
        run("R11 midwrite", 9, 1, 1'b0, 5);
        run("R11 next start", 9, 1, 1'b0, -1);

        // Random configurations covering R3 gaps, R6 fields and R7 orders
        for (int n = 0; n < 40; n++) begin
            for (int a = 0; a < 4; a++) wr(a, 29'($urandom));
            slot_sel = 12'($urandom);
            run("R3 R6 R7 random", int'($urandom % 128), int'($urandom % 4), 1'b1,
                (n % 5 == 0) ? 2 : -1);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule